// File: doc/BRIEF.md
# Accumulating Register Loop with Banked Upper Half

This block is the register-and-adder loop of a small byte-wide processor. It holds eight 8-bit registers and feeds two of them into an adder. The pair that drives the adder is not named by each arithmetic operation. A separate select operation latches the two read addresses, and they stay in force until the next select. An arithmetic operation names only the register that receives the result. Writing into one of the two latched sources changes the adder input on the very next cycle, so a short sequence of adds behaves like an accumulator. With registers 1 and 2 holding 1, alternately adding into 1 and into 2 steps through the Fibonacci numbers.

Registers 4 to 7 exist once per register context. Registers 0 to 3 are common to all contexts. The carry flag exists once per flag context. The latched read pair exists once per select context. A context-set operation loads all three context selectors together. An immediate write port puts an external byte into any register, with the same timing and the same effect on the read paths as an arithmetic write.

Top module: `accumDataloop`

## Requirements
- R1: While reset (rstN low) is applied and on the first cycle after it, opA, opB and carryFlag are 0. Every register, carry flag, context selector and latched read address resets to 0.
- R2: A select operation (selValid) latches selAddrA and selAddrB into the pair of the active select context. From the next cycle, opA and opB show those registers, and they keep showing them until another select or context change. A cycle with no operation leaves opA, opB and carryFlag unchanged.
- R3: An arithmetic operation with aluOp=0 (add) writes (opA+opB) mod 256 to aluDest at the clock edge. The carry flag of the active flag context takes the carry out of bit 7.
- R4: A write to a register that is currently latched as a source appears on opA or opB in the cycle after the write edge. Alternate adds into registers 1 and 2, each starting at 1, give Fibonacci values.
- R5: With aluOp=1 (add with carry), the stored carry of the active flag context is added as a third term. The carry flag is updated from the carry out of that sum.
- R6: immValid writes immData to immDest with the same timing as an arithmetic write. If aluValid and immValid are both high in a cycle, only the arithmetic write happens and the immediate is dropped, even when its destination differs.
- R7: Addresses 4 to 7 (address bit 2 set) select the copy that belongs to the current register context. Addresses 0 to 3 are one shared copy.
- R8: carryFlag shows the carry of the current flag context. Each flag context keeps its own carry.
- R9: Each select context keeps its own latched read pair. Switching the select context brings back the pair last latched in it.
- R10: ctxValid loads ctxRegIn, ctxFlagIn and ctxSelIn at the clock edge. Any select, arithmetic or immediate operation in the same cycle uses the contexts that were in force before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selValid | input | 1 | Latch a new read pair |
| selAddrA | input | 3 | Register address for adder input A |
| selAddrB | input | 3 | Register address for adder input B |
| aluValid | input | 1 | Perform an arithmetic operation |
| aluOp | input | 1 | 0 = add, 1 = add with stored carry |
| aluDest | input | 3 | Destination register of the arithmetic result |
| immValid | input | 1 | Write an immediate byte |
| immDest | input | 3 | Destination register of the immediate |
| immData | input | 8 | Immediate byte |
| ctxValid | input | 1 | Load the three context selectors |
| ctxRegIn | input | 1 | New register context |
| ctxFlagIn | input | 1 | New flag context |
| ctxSelIn | input | 1 | New select context |
| opA | output | 8 | Current value of the latched A register |
| opB | output | 8 | Current value of the latched B register |
| carryFlag | output | 1 | Carry of the active flag context |

## Verification
The bench runs the Fibonacci loop past a byte overflow. A design that buffered the adder inputs would repeat stale sums, and one that mishandled the carry would miss the wrap at 377. It collides an arithmetic write with an immediate write, which catches a wrong priority or a partial immediate write. It changes contexts in the same cycle as an add, which shows whether the write lands in the old bank. It switches the register, flag and select contexts on their own, so that a bank shared by mistake shows up as a value leaking between contexts. A long stretch of random operations is then checked every cycle against a behavioural model.

// File: rtl/dlPkg.sv
package dlPkg;
  localparam int DL_ADDR_W = 3;
  localparam int DL_CTX_W  = 1;

  typedef enum logic {OP_ADD = 1'b0, OP_ADDC = 1'b1} aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic                 wrFromAlu;
    logic [DL_ADDR_W-1:0] wrAddr;
    logic [DL_ADDR_W-1:0] rdAddrA;
    logic [DL_ADDR_W-1:0] rdAddrB;
    logic [DL_CTX_W-1:0]  bankSel;
    logic                 carryIn;
  } dlStrobe_t;
endpackage

// File: rtl/dlDatapath.sv
module dlDatapath
  import dlPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlStrobe_t         stb,
  input  logic [DATA_W-1:0] immData,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic              carryOut
);
  localparam int HALF    = 1 << (DL_ADDR_W - 1);
  localparam int NUM_CTX = 1 << DL_CTX_W;
  localparam int LOW_W   = DL_ADDR_W - 1;

  logic [DATA_W-1:0] sharedQ [HALF];
  logic [DATA_W-1:0] bankQ   [NUM_CTX][HALF];
  logic [DATA_W:0]   sumW;
  logic [DATA_W-1:0] wrData;

  function automatic logic [DATA_W-1:0] readReg(input logic [DL_ADDR_W-1:0] addr,
                                                input logic [DL_CTX_W-1:0]  bank);
    if (addr[DL_ADDR_W-1]) return bankQ[bank][addr[LOW_W-1:0]];
    else                   return sharedQ[addr[LOW_W-1:0]];
  endfunction

  // open read paths: no buffering between registers and adder
  always_comb begin
    opA      = readReg(stb.rdAddrA, stb.bankSel);
    opB      = readReg(stb.rdAddrB, stb.bankSel);
    sumW     = {1'b0, opA} + {1'b0, opB} + (DATA_W+1)'(stb.carryIn);
    carryOut = sumW[DATA_W];
    wrData   = stb.wrFromAlu ? sumW[DATA_W-1:0] : immData;
  end

  for (genvar i = 0; i < HALF; i++) begin : g_shared
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sharedQ[i] <= '0;
      else if (stb.wrEn && !stb.wrAddr[DL_ADDR_W-1] &&
               stb.wrAddr[LOW_W-1:0] == LOW_W'(i))
        sharedQ[i] <= wrData;
    end
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    for (genvar i = 0; i < HALF; i++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bankQ[c][i] <= '0;
        else if (stb.wrEn && stb.wrAddr[DL_ADDR_W-1] &&
                 stb.bankSel == DL_CTX_W'(c) &&
                 stb.wrAddr[LOW_W-1:0] == LOW_W'(i))
          bankQ[c][i] <= wrData;
      end
    end
  end
endmodule

// File: rtl/dlControl.sv
module dlControl
  import dlPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 selValid,
  input  logic [DL_ADDR_W-1:0] selAddrA,
  input  logic [DL_ADDR_W-1:0] selAddrB,
  input  logic                 aluValid,
  input  logic                 aluOp,
  input  logic [DL_ADDR_W-1:0] aluDest,
  input  logic                 immValid,
  input  logic [DL_ADDR_W-1:0] immDest,
  input  logic                 ctxValid,
  input  logic [DL_CTX_W-1:0]  ctxRegIn,
  input  logic [DL_CTX_W-1:0]  ctxFlagIn,
  input  logic [DL_CTX_W-1:0]  ctxSelIn,
  input  logic                 carryOut,
  output dlStrobe_t            stb,
  output logic                 carryFlag
);
  localparam int NUM_CTX = 1 << DL_CTX_W;

  logic [DL_ADDR_W-1:0] selAQ [NUM_CTX];
  logic [DL_ADDR_W-1:0] selBQ [NUM_CTX];
  logic                 carryQ [NUM_CTX];
  logic [DL_CTX_W-1:0]  regCtxQ, flagCtxQ, selCtxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regCtxQ  <= '0;
      flagCtxQ <= '0;
      selCtxQ  <= '0;
    end else if (ctxValid) begin
      regCtxQ  <= ctxRegIn;
      flagCtxQ <= ctxFlagIn;
      selCtxQ  <= ctxSelIn;
    end
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selAQ[c] <= '0;
        selBQ[c] <= '0;
      end else if (selValid && selCtxQ == DL_CTX_W'(c)) begin
        selAQ[c] <= selAddrA;
        selBQ[c] <= selAddrB;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) carryQ[c] <= 1'b0;
      else if (aluValid && flagCtxQ == DL_CTX_W'(c)) carryQ[c] <= carryOut;
    end
  end

  always_comb begin
    carryFlag     = carryQ[flagCtxQ];
    stb.wrEn      = aluValid | immValid;
    stb.wrFromAlu = aluValid;
    stb.wrAddr    = aluValid ? aluDest : immDest;
    stb.rdAddrA   = selAQ[selCtxQ];
    stb.rdAddrB   = selBQ[selCtxQ];
    stb.bankSel   = regCtxQ;
    stb.carryIn   = (aluOp == OP_ADDC) ? carryQ[flagCtxQ] : 1'b0;
  end
endmodule

// File: rtl/accumDataloop.sv
module accumDataloop
  import dlPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 selValid,
  input  logic [DL_ADDR_W-1:0] selAddrA,
  input  logic [DL_ADDR_W-1:0] selAddrB,
  input  logic                 aluValid,
  input  logic                 aluOp,
  input  logic [DL_ADDR_W-1:0] aluDest,
  input  logic                 immValid,
  input  logic [DL_ADDR_W-1:0] immDest,
  input  logic [DATA_W-1:0]    immData,
  input  logic                 ctxValid,
  input  logic [DL_CTX_W-1:0]  ctxRegIn,
  input  logic [DL_CTX_W-1:0]  ctxFlagIn,
  input  logic [DL_CTX_W-1:0]  ctxSelIn,
  output logic [DATA_W-1:0]    opA,
  output logic [DATA_W-1:0]    opB,
  output logic                 carryFlag
);
  dlStrobe_t stb;
  logic      carryOut;

  dlControl u_ctrl (
    .clk(clk), .rstN(rstN),
    .selValid(selValid), .selAddrA(selAddrA), .selAddrB(selAddrB),
    .aluValid(aluValid), .aluOp(aluOp), .aluDest(aluDest),
    .immValid(immValid), .immDest(immDest),
    .ctxValid(ctxValid), .ctxRegIn(ctxRegIn), .ctxFlagIn(ctxFlagIn), .ctxSelIn(ctxSelIn),
    .carryOut(carryOut), .stb(stb), .carryFlag(carryFlag)
  );

  dlDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .immData(immData),
    .opA(opA), .opB(opB), .carryOut(carryOut)
  );
endmodule

// File: rtl/dlChecker.sv
module dlChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              selValid,
  input logic              aluValid,
  input logic              aluOp,
  input logic              immValid,
  input logic              ctxValid,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              carryFlag
);
  logic [DATA_W:0] plainSum, carrySum;
  always_comb begin
    plainSum = {1'b0, opA} + {1'b0, opB};
    carrySum = plainSum + (DATA_W+1)'(carryFlag);
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |=> (opA == '0 && opB == '0 && !carryFlag));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!selValid && !aluValid && !immValid && !ctxValid) |=>
      ($stable(opA) && $stable(opB) && $stable(carryFlag)));

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (aluValid && !aluOp && !ctxValid) |=> carryFlag == $past(plainSum[DATA_W]));

  assert_addc_carry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aluValid && aluOp && !ctxValid) |=> carryFlag == $past(carrySum[DATA_W]));

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!aluValid && !ctxValid) |=> $stable(carryFlag));
endmodule

bind accumDataloop dlChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .selValid(selValid), .aluValid(aluValid),
  .aluOp(aluOp), .immValid(immValid), .ctxValid(ctxValid),
  .opA(opA), .opB(opB), .carryFlag(carryFlag)
);

// File: tb/accumDataloop_tb.sv
module accumDataloop_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selValid = 0, aluValid = 0, aluOp = 0, immValid = 0, ctxValid = 0;
  logic [2:0] selAddrA = 0, selAddrB = 0, aluDest = 0, immDest = 0;
  logic [7:0] immData = 0;
  logic ctxRegIn = 0, ctxFlagIn = 0, ctxSelIn = 0;
  logic [7:0] opA, opB;
  logic carryFlag;

  int nChecks = 0;
  int nFail = 0;

  // behavioural reference state
  int mShared [4];
  int mBank [2][4];
  int mCarry [2];
  int mSelA [2];
  int mSelB [2];
  int mRegCtx, mFlagCtx, mSelCtx;

  always #(CLK_PERIOD/2) clk = ~clk;

  accumDataloop u_dut (
    .clk(clk), .rstN(rstN),
    .selValid(selValid), .selAddrA(selAddrA), .selAddrB(selAddrB),
    .aluValid(aluValid), .aluOp(aluOp), .aluDest(aluDest),
    .immValid(immValid), .immDest(immDest), .immData(immData),
    .ctxValid(ctxValid), .ctxRegIn(ctxRegIn), .ctxFlagIn(ctxFlagIn), .ctxSelIn(ctxSelIn),
    .opA(opA), .opB(opB), .carryFlag(carryFlag)
  );

  function automatic int mRead(int addr, int ctx);
    if (addr >= 4) return mBank[ctx][addr-4];
    return mShared[addr];
  endfunction

  task automatic mWrite(int addr, int ctx, int val);
    if (addr >= 4) mBank[ctx][addr-4] = val;
    else mShared[addr] = val;
  endtask

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    int a, b, s;
    a = mRead(mSelA[mSelCtx], mRegCtx);
    b = mRead(mSelB[mSelCtx], mRegCtx);
    s = a + b + ((aluOp == 1'b1) ? mCarry[mFlagCtx] : 0);
    if (aluValid) begin
      mWrite(int'(aluDest), mRegCtx, s % 256);
      mCarry[mFlagCtx] = (s > 255) ? 1 : 0;
    end else if (immValid) begin
      mWrite(int'(immDest), mRegCtx, int'(immData));
    end
    if (selValid) begin
      mSelA[mSelCtx] = int'(selAddrA);
      mSelB[mSelCtx] = int'(selAddrB);
    end
    if (ctxValid) begin
      mRegCtx = int'(ctxRegIn);
      mFlagCtx = int'(ctxFlagIn);
      mSelCtx = int'(ctxSelIn);
    end
  endtask

  // one clock: update model, pass the edge, compare away from the edge
  task automatic cycle();
    modelStep();
    @(posedge clk); #1;
    selValid = 0; aluValid = 0; immValid = 0; ctxValid = 0; aluOp = 0;
    chk("R2 R4 model opA", int'(opA), mRead(mSelA[mSelCtx], mRegCtx));
    chk("R2 R4 model opB", int'(opB), mRead(mSelB[mSelCtx], mRegCtx));
    chk("R3 R8 model carry", int'(carryFlag), mCarry[mFlagCtx]);
  endtask

  task automatic doSel(int a, int b);
    selValid = 1; selAddrA = 3'(a); selAddrB = 3'(b); cycle();
  endtask
  task automatic doAlu(int op, int dest);
    aluValid = 1; aluOp = op[0]; aluDest = 3'(dest); cycle();
  endtask
  task automatic doImm(int dest, int val);
    immValid = 1; immDest = 3'(dest); immData = 8'(val); cycle();
  endtask
  task automatic doCtx(int r, int f, int s);
    ctxValid = 1; ctxRegIn = r[0]; ctxFlagIn = f[0]; ctxSelIn = s[0]; cycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    foreach (mShared[i]) mShared[i] = 0;
    foreach (mBank[c, i]) mBank[c][i] = 0;
    mCarry[0] = 0; mCarry[1] = 0;
    mSelA[0] = 0; mSelA[1] = 0; mSelB[0] = 0; mSelB[1] = 0;
    mRegCtx = 0; mFlagCtx = 0; mSelCtx = 0;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset opA", int'(opA), 0);
    chk("R1 reset opB", int'(opB), 0);
    chk("R1 reset carry", int'(carryFlag), 0);
    rstN = 1;
    cycle();

    // R4: Fibonacci through open read paths
    doImm(1, 1);
    doImm(2, 1);
    doSel(1, 2);
    for (int k = 0; k < 10; k++) doAlu(0, (k % 2 == 0) ? 1 : 2);
    chk("R4 fib opA", int'(opA), 89);
    chk("R4 fib opB", int'(opB), 144);
    chk("R3 fib no carry", int'(carryFlag), 0);
    doAlu(0, 1);
    doAlu(0, 2);
    chk("R4 fib wrap opA", int'(opA), 233);
    chk("R3 fib wrap opB", int'(opB), 121);
    chk("R3 fib carry out", int'(carryFlag), 1);

    // R5: add with stored carry
    doImm(3, 200);
    doImm(0, 100);
    doSel(3, 0);
    doAlu(0, 5);
    chk("R3 add carry set", int'(carryFlag), 1);
    doSel(5, 0);
    chk("R3 add low byte", int'(opA), 44);
    doAlu(1, 6);
    doSel(6, 6);
    chk("R5 addc result", int'(opA), 145);
    chk("R5 addc carry clear", int'(carryFlag), 0);

    // R7: banked upper registers
    doCtx(1, 0, 0);
    doImm(4, 77);
    doImm(0, 9);
    doSel(4, 0);
    chk("R7 ctx1 r4", int'(opA), 77);
    chk("R7 shared r0", int'(opB), 9);
    doCtx(0, 0, 0);
    chk("R7 ctx0 r4 untouched", int'(opA), 0);
    chk("R7 shared r0 ctx0", int'(opB), 9);

    // R8: banked carry
    doImm(7, 200);
    doSel(7, 7);
    doAlu(0, 3);
    chk("R8 carry ctx0 set", int'(carryFlag), 1);
    doCtx(0, 1, 0);
    chk("R8 carry ctx1 clear", int'(carryFlag), 0);
    doCtx(0, 0, 0);
    chk("R8 carry ctx0 kept", int'(carryFlag), 1);

    // R9: banked read pair
    doCtx(0, 0, 1);
    chk("R9 sel ctx1 reset pair", int'(opA), 9);
    doSel(3, 1);
    chk("R9 sel ctx1 new pair", int'(opA), 144);
    doCtx(0, 0, 0);
    chk("R9 sel ctx0 restored", int'(opA), 200);

    // R6: arithmetic wins over immediate
    aluValid = 1; aluOp = 0; aluDest = 3'd2;
    immValid = 1; immDest = 3'd2; immData = 8'd5;
    cycle();
    doSel(2, 2);
    chk("R6 alu wins same dest", int'(opA), 144);
    aluValid = 1; aluOp = 0; aluDest = 3'd1;
    immValid = 1; immDest = 3'd0; immData = 8'd33;
    cycle();
    doSel(0, 1);
    chk("R6 imm dropped other dest", int'(opA), 9);
    chk("R6 alu result", int'(opB), 32);

    // R10: context change in the same cycle as an add
    aluValid = 1; aluOp = 0; aluDest = 3'd4;
    ctxValid = 1; ctxRegIn = 1; ctxFlagIn = 1; ctxSelIn = 0;
    cycle();
    chk("R10 new flag ctx carry", int'(carryFlag), 0);
    doSel(4, 4);
    chk("R10 ctx1 r4 unchanged", int'(opA), 77);
    doCtx(0, 0, 0);
    chk("R10 write in old bank", int'(opA), 41);

    // random mix checked against the model every cycle (R2 R3 R5 R6 R7 R8 R9 R10)
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      selValid = (r == 0 || r == 5);
      aluValid = (r >= 2 && r <= 4) || r == 5;
      immValid = (r == 1 || r == 4 || r == 6);
      ctxValid = (r == 7);
      aluOp = 1'($urandom_range(0, 1));
      selAddrA = 3'($urandom_range(0, 7));
      selAddrB = 3'($urandom_range(0, 7));
      aluDest = 3'($urandom_range(0, 7));
      immDest = 3'($urandom_range(0, 7));
      immData = 8'($urandom_range(0, 255));
      ctxRegIn = 1'($urandom_range(0, 1));
      ctxFlagIn = 1'($urandom_range(0, 1));
      ctxSelIn = 1'($urandom_range(0, 1));
      cycle();
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule